// File: doc/BRIEF.md
# Register-Mapped Up-Counting Timer

The block is a 32-bit up-counter with a small register file on a synchronous write bus and a combinational read port. Software sets a reload value, a compare value and a control word, then starts the counter. The counter either advances on every clock or, with the divider enabled, once per 2^(e+1) clocks, where e is a 3-bit exponent. When it passes 0xFFFFFFFF it either reloads and keeps running or stops at zero. Crossing the compare value raises a match event. A software trigger register copies the reload value into the counter.

Match and overflow events set bits in a sticky status register, but only for the sources whose interrupt enable bit is set. The interrupt output is high while any status bit is set. Software clears a status bit by writing 1 to it. A separate wake-up enable mask turns any event into a one-cycle wake pulse, whatever the interrupt enables hold. A soft reset through the configuration register returns every register to zero.

Top module: `upcount_timer`

## Requirements
- R1: After rst_n is released, every register reads 0, irq_o is low and wake_o is low.
- R2: The byte offsets are 0x10 config, 0x18 status, 0x1C interrupt enable, 0x20 wake enable, 0x24 control, 0x28 counter, 0x2C reload, 0x30 trigger and 0x38 compare. Config keeps only the bits in 0x33D. Both enables keep bits 2:0. The trigger offset reads 0xFFFFFFFF. Any other offset reads 0.
- R3: The control word is laid out as bit0 run, bit1 auto-reload, bits4:2 divider exponent e, bit5 divider enable and bit6 compare enable. Bits 14:7 are stored and read back but do not affect counting.
- R4: With run set and the divider off, the counter rises by one on every clock. With run clear it holds its value.
- R5: With the divider on, the counter advances once every 2^(e+1) clocks. The divider phase restarts on any write to the counter, trigger or control offset, and while run or divider enable is clear.
- R6: An advance from 0xFFFFFFFF is an overflow event. With auto-reload set, the counter takes the reload value and keeps running.
- R7: On overflow with auto-reload clear, the counter becomes 0 and the run bit clears.
- R8: A write to the counter offset loads the written data on that clock edge. A write of any data to the trigger offset loads the reload value. Either write takes priority over counting in that cycle and raises no event.
- R9: With compare enable set, a match event occurs on the clock where an increment makes the counter equal to the compare value. A reload, a counter write or a trigger write that lands on the compare value does not match. A compare value below the counter does not match until the count wraps around.
- R10: Status bit 0 is match, bit 1 is overflow and bit 2 is capture, which is never set here. A bit is set, on the same edge the counter changes, only if its interrupt enable bit is 1. irq_o is high exactly while status is non-zero.
- R11: Writing 1 to a status bit clears it. If an event sets that bit in the same cycle, the set wins.
- R12: An event whose wake enable bit is set drives wake_o high for the one cycle after the edge on which the event occurs, regardless of the interrupt enable.
- R13: Writing 1 to bit 1 of the config offset returns every register, including config, to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt, high while any status bit is set |
| wake_o | output | 1 | One-cycle wake-up pulse |

## Verification
Most internal state shows up on the read port within one cycle, so a wrong counter step, reload or one-shot stop makes the counter reading differ on the first sampled cycle after the faulty edge. A divider phase error shows only as a late or early increment, which takes up to 2^(e+1) cycles to appear. That is why the divider is run with small exponents and compared every cycle. A wrong mask or event on the status path shows on irq_o and wake_o in the cycle after the event. The reference model, stepped on every clock edge, sees that directly.

// File: rtl/tmr_pkg.sv
// Package: shared widths, register offsets, event bit positions and the
// control word layout of the up-counting timer.
// Assumes: byte-offset addressing on an 8-bit address, 32-bit data.
package tmr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int PTV_W  = 3;
    localparam int EVT_W  = 3;
    localparam int CTL_W  = 15;

    localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STS  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_WEN  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_LOAD = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_TRG  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MAT  = 8'h38;

    localparam logic [DATA_W-1:0] CFG_KEEP = 32'h0000_033D;
    localparam int CFG_SRST_BIT = 1;

    localparam int EVT_MAT = 0;
    localparam int EVT_OVF = 1;
    localparam int EVT_CAP = 2;

    // Control word; the first member is the most significant bit (bit 14).
    typedef struct packed {
        logic             pin_dir;
        logic             cap_sel;
        logic             pulse_sel;
        logic [1:0]       trig_mode;
        logic [1:0]       cap_mode;
        logic             idle_lvl;
        logic             cmp_en;
        logic             div_en;
        logic [PTV_W-1:0] div_exp;
        logic             reload;
        logic             run;
    } ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Produces the count enable for the timer. With the divider off it is high
// on every clock while running. With the divider on it is high once every
// 2^(exp+1) clocks.
// Assumes: clr restarts the phase; the phase stays at zero while stopped.
module tmr_prescaler #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             div_en,
    input  logic [PTV_W-1:0] div_exp,
    output logic             tick
);
    localparam int PRE_W = 2 ** PTV_W;

    logic [PRE_W-1:0] phase;
    logic [PRE_W:0]   span;

    // Last phase value of one divided period: 2^(exp+1) - 1.
    always_comb begin
        span = ((PRE_W+1)'(1) << ((PTV_W+1)'(div_exp) + (PTV_W+1)'(1))) - (PRE_W+1)'(1);
    end

    // Count enable for this cycle.
    always_comb begin
        tick = run & (~div_en | (phase == span[PRE_W-1:0]));
    end

    // Phase counter: wraps on tick, held at zero when idle or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clr || !run || !div_en || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + PRE_W'(1);
        end
    end
endmodule

// File: rtl/tmr_count.sv
// Module: tmr_count
// Holds the 32-bit counter. It detects overflow and match on each
// increment, reloads or stops at zero on overflow, and accepts direct loads.
// Assumes: a load (counter or trigger write) beats counting and raises no event.
module tmr_count #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tick,
    input  logic              reload,
    input  logic              cmp_en,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_val,
    input  logic [DATA_W-1:0] reload_val,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] cnt,
    output logic              ovf_evt,
    output logic              mat_evt,
    output logic              stop_req
);
    logic              at_top;
    logic [DATA_W-1:0] nxt;

    // Next incremented value and the wrap condition.
    always_comb begin
        at_top = &cnt;
        nxt    = cnt + DATA_W'(1);
    end

    // Events from this cycle's advance.
    always_comb begin
        ovf_evt  = tick & at_top & ~ld_en;
        mat_evt  = tick & ~at_top & ~ld_en & cmp_en & (nxt == cmp_val);
        stop_req = ovf_evt & ~reload;
    end

    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt <= '0;
        end else if (ld_en) begin
            cnt <= ld_val;
        end else if (ovf_evt) begin
            cnt <= reload ? reload_val : '0;
        end else if (tick) begin
            cnt <= nxt;
        end
    end
endmodule

// File: rtl/tmr_irq.sv
// Module: tmr_irq
// Sticky status with write-1-to-clear, masked by the interrupt enables, plus
// a registered wake pulse masked by the wake enables.
// Assumes: an event that sets a bit beats a clear of the same bit in a cycle.
module tmr_irq #(
    parameter int EVT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [EVT_W-1:0] evt,
    input  logic [EVT_W-1:0] int_en,
    input  logic [EVT_W-1:0] wake_en,
    input  logic             clr_wr,
    input  logic [EVT_W-1:0] clr_mask,
    output logic [EVT_W-1:0] status,
    output logic             irq,
    output logic             wake
);
    logic [EVT_W-1:0] status_nxt;

    // Next status: clear the written ones, then set the enabled events.
    always_comb begin
        status_nxt = (status & ~(clr_wr ? clr_mask : '0)) | (evt & int_en);
    end

    // Status and wake registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            status <= '0;
            wake   <= 1'b0;
        end else begin
            status <= status_nxt;
            wake   <= |(evt & wake_en);
        end
    end

    // Interrupt line follows the sticky status.
    always_comb begin
        irq = |status;
    end
endmodule

// File: rtl/upcount_timer.sv
// Module: upcount_timer (top)
// Register file, write decode and read mux of the up-counting timer. It ties
// together the divider, the counter and the interrupt logic.
// Assumes: one write per cycle, sampled on the rising edge; reads are
// combinational from bus_addr; synchronous active-low reset.
module upcount_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              wake_o
);
    logic [DATA_W-1:0] cfg_q, reload_q, cmp_q, cnt;
    logic [EVT_W-1:0]  ien_q, wen_q, status, evt;
    ctl_t              ctl_q;
    logic              soft_rst, ctl_wr, cnt_ld, tick, ovf_evt, mat_evt, stop_req;
    logic              sts_wr;
    logic [DATA_W-1:0] ld_val;

    // Write decode.
    always_comb begin
        soft_rst = bus_we && (bus_addr == OFS_CFG) && bus_wdata[CFG_SRST_BIT];
        ctl_wr   = bus_we && (bus_addr == OFS_CTL);
        sts_wr   = bus_we && (bus_addr == OFS_STS);
        cnt_ld   = bus_we && ((bus_addr == OFS_CNT) || (bus_addr == OFS_TRG));
        ld_val   = (bus_addr == OFS_CNT) ? bus_wdata : reload_q;
    end

    // Plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cfg_q    <= '0;
            ien_q    <= '0;
            wen_q    <= '0;
            reload_q <= '0;
            cmp_q    <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_CFG:  cfg_q    <= bus_wdata & CFG_KEEP;
                OFS_IEN:  ien_q    <= bus_wdata[EVT_W-1:0];
                OFS_WEN:  wen_q    <= bus_wdata[EVT_W-1:0];
                OFS_LOAD: reload_q <= bus_wdata;
                OFS_MAT:  cmp_q    <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Control word: software writes win over the one-shot stop.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= ctl_t'(bus_wdata[CTL_W-1:0]);
        end else if (stop_req) begin
            ctl_q.run <= 1'b0;
        end
    end

    tmr_prescaler #(.PTV_W(PTV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst | cnt_ld | ctl_wr),
        .run     (ctl_q.run),
        .div_en  (ctl_q.div_en),
        .div_exp (ctl_q.div_exp),
        .tick    (tick)
    );

    tmr_count #(.DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .tick       (tick),
        .reload     (ctl_q.reload),
        .cmp_en     (ctl_q.cmp_en),
        .ld_en      (cnt_ld),
        .ld_val     (ld_val),
        .reload_val (reload_q),
        .cmp_val    (cmp_q),
        .cnt        (cnt),
        .ovf_evt    (ovf_evt),
        .mat_evt    (mat_evt),
        .stop_req   (stop_req)
    );

    // Event vector in status bit order; capture is never raised here.
    always_comb begin
        evt          = '0;
        evt[EVT_MAT] = mat_evt;
        evt[EVT_OVF] = ovf_evt;
        evt[EVT_CAP] = 1'b0;
    end

    tmr_irq #(.EVT_W(EVT_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .evt      (evt),
        .int_en   (ien_q),
        .wake_en  (wen_q),
        .clr_wr   (sts_wr),
        .clr_mask (bus_wdata[EVT_W-1:0]),
        .status   (status),
        .irq      (irq_o),
        .wake     (wake_o)
    );

    // Read mux.
    always_comb begin
        case (bus_addr)
            OFS_CFG:  bus_rdata = cfg_q;
            OFS_STS:  bus_rdata = DATA_W'(status);
            OFS_IEN:  bus_rdata = DATA_W'(ien_q);
            OFS_WEN:  bus_rdata = DATA_W'(wen_q);
            OFS_CTL:  bus_rdata = DATA_W'(ctl_q);
            OFS_CNT:  bus_rdata = cnt;
            OFS_LOAD: bus_rdata = reload_q;
            OFS_TRG:  bus_rdata = '1;
            OFS_MAT:  bus_rdata = cmp_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
// Module: tmr_checker
// Temporal checks on the timer's counter, one-shot stop, status, wake and
// soft reset. It is attached to upcount_timer with the bind below.
// Assumes: synchronous active-low reset; all checks are off during reset.
module tmr_checker #(
    parameter int DATA_W = 32,
    parameter int EVT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              cnt_ld,
    input logic              ctl_wr,
    input logic              tick,
    input logic              ovf_evt,
    input logic              mat_evt,
    input logic              run,
    input logic              reload,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] reload_val,
    input logic [EVT_W-1:0]  ien,
    input logic [EVT_W-1:0]  wen,
    input logic [EVT_W-1:0]  status,
    input logic              wake
);
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !cnt_ld && tick && !(&cnt)) |=> (cnt == $past(cnt) + DATA_W'(1)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !cnt_ld && !tick) |=> $stable(cnt));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && ovf_evt && reload) |=> (cnt == $past(reload_val)));

    assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && ovf_evt && !reload && !ctl_wr) |=> (!run && cnt == '0));

    assert_status_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && ovf_evt && ien[1]) |=> status[1]);

    assert_status_mat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && mat_evt && ien[0]) |=> status[0]);

    assert_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && ((ovf_evt && wen[1]) || (mat_evt && wen[0]))) |=> wake);

    assert_soft_reset_R13: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status == '0 && cnt == '0 && !run && !wake));
endmodule

bind upcount_timer tmr_checker #(.DATA_W(tmr_pkg::DATA_W), .EVT_W(tmr_pkg::EVT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .cnt_ld     (cnt_ld),
    .ctl_wr     (ctl_wr),
    .tick       (tick),
    .ovf_evt    (ovf_evt),
    .mat_evt    (mat_evt),
    .run        (ctl_q.run),
    .reload     (ctl_q.reload),
    .cnt        (cnt),
    .reload_val (reload_q),
    .ien        (ien_q),
    .wen        (wen_q),
    .status     (status),
    .wake       (wake_o)
);

// File: tb/upcount_timer_bench.sv
// Bench: a behavioural per-clock reference model of the timer. It is compared
// against irq_o, wake_o and the read port on every falling edge.
module upcount_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h28;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, wake_o;

    upcount_timer u_upcount_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .wake_o(wake_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    int    vectors = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";
    logic [7:0] mon_addr = 8'h28;

    // Reference model state.
    logic [31:0] m_cfg = 0, m_cnt = 0, m_load = 0, m_match = 0;
    logic [14:0] m_ctl = 0;
    logic [2:0]  m_st = 0, m_ien = 0, m_wen = 0, m_evt;
    logic        m_wake = 0;
    int          m_pre = 0;
    int          lim, np;
    bit          tk, ov, mt, run, ar, pe, ce;
    logic [31:0] nc;

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h10: return m_cfg;
            8'h18: return {29'd0, m_st};
            8'h1C: return {29'd0, m_ien};
            8'h20: return {29'd0, m_wen};
            8'h24: return {17'd0, m_ctl};
            8'h28: return m_cnt;
            8'h2C: return m_load;
            8'h30: return 32'hFFFF_FFFF;
            8'h38: return m_match;
            default: return 32'd0;
        endcase
    endfunction

    // Model step on each rising edge, written from the requirements.
    always @(posedge clk) begin
        if (!rst_n || (bus_we && bus_addr == 8'h10 && bus_wdata[1])) begin
            m_cfg = 0; m_cnt = 0; m_load = 0; m_match = 0; m_ctl = 0;
            m_st = 0; m_ien = 0; m_wen = 0; m_wake = 0; m_pre = 0;
        end else begin
            run = m_ctl[0]; ar = m_ctl[1]; pe = m_ctl[5]; ce = m_ctl[6];
            lim = (2 << m_ctl[4:2]) - 1;
            tk = run && (!pe || m_pre == lim);
            np = (!run || !pe || tk) ? 0 : m_pre + 1;
            ov = 0; mt = 0; nc = m_cnt;
            if (bus_we && (bus_addr == 8'h28 || bus_addr == 8'h30)) begin
                nc = (bus_addr == 8'h28) ? bus_wdata : m_load;
                np = 0;
            end else if (tk) begin
                if (m_cnt == 32'hFFFF_FFFF) begin
                    ov = 1; nc = ar ? m_load : 32'd0;
                end else begin
                    nc = m_cnt + 1;
                    mt = ce && (nc == m_match);
                end
            end
            m_evt = {1'b0, ov, mt};
            m_st = (m_st & ~((bus_we && bus_addr == 8'h18) ? bus_wdata[2:0] : 3'd0)) | (m_evt & m_ien);
            m_wake = |(m_evt & m_wen);
            if (bus_we && bus_addr == 8'h24) begin
                m_ctl = bus_wdata[14:0];
                np = 0;
            end else if (ov && !ar) begin
                m_ctl[0] = 1'b0;
            end
            if (bus_we) begin
                case (bus_addr)
                    8'h10: m_cfg = bus_wdata & 32'h33D;
                    8'h1C: m_ien = bus_wdata[2:0];
                    8'h20: m_wen = bus_wdata[2:0];
                    8'h2C: m_load = bus_wdata;
                    8'h38: m_match = bus_wdata;
                    default: ;
                endcase
            end
            m_cnt = nc;
            m_pre = np;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            vectors++;
            if (irq_o !== (m_st != 0)) begin
                errors++;
                $display("FAIL %s irq_o: actual %b expected %b", cur_req, irq_o, m_st != 0);
            end
            if (wake_o !== m_wake) begin
                errors++;
                $display("FAIL %s wake_o: actual %b expected %b", cur_req, wake_o, m_wake);
            end
            if (bus_rdata !== exp_rd(bus_addr)) begin
                errors++;
                $display("FAIL %s rdata@%h: actual %h expected %h", cur_req, bus_addr, bus_rdata, exp_rd(bus_addr));
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_we = 1'b0; bus_addr = mon_addr;
    endtask

    task automatic sweep();
        logic [7:0] offs [11] = '{8'h10, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h38, 8'h04, 8'h34};
        for (int i = 0; i < 11; i++) begin
            bus_addr = offs[i];
            @(posedge clk); #2;
        end
        bus_addr = mon_addr;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        chk_on = 1'b1;
        #0;
        cur_req = "R1"; sweep();

        cur_req = "R2";
        wr(8'h1C, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFF8);
        wr(8'h10, 32'hFFFF_FFFD); wr(8'h2C, 32'h1234_5678); wr(8'h38, 32'hCAFE_0001);
        sweep();
        wr(8'h1C, 0); wr(8'h20, 0);

        cur_req = "R3";
        wr(8'h28, 32'd5); wr(8'h24, 32'h7F80); mon_addr = 8'h24; idle(1);
        mon_addr = 8'h28; idle(4);

        cur_req = "R4";
        wr(8'h28, 32'd100); wr(8'h24, 32'h1); idle(10);
        wr(8'h24, 32'h0); idle(4);

        cur_req = "R5";
        wr(8'h28, 32'd0); wr(8'h24, 32'h21); idle(16);
        wr(8'h24, 32'h29); idle(20);
        wr(8'h28, 32'd7); idle(20);

        cur_req = "R6";
        wr(8'h1C, 32'h2); wr(8'h2C, 32'h10); wr(8'h28, 32'hFFFF_FFFC);
        wr(8'h24, 32'h3); idle(10);

        cur_req = "R11";
        wr(8'h18, 32'h2); idle(3);

        cur_req = "R7";
        wr(8'h28, 32'hFFFF_FFFE); wr(8'h24, 32'h1); idle(4);
        mon_addr = 8'h24; idle(2); mon_addr = 8'h28; idle(2);

        cur_req = "R8";
        wr(8'h2C, 32'h500); wr(8'h24, 32'h1); idle(3);
        wr(8'h30, 32'h0BAD_F00D); idle(3);
        wr(8'h28, 32'h4000); idle(3);

        cur_req = "R9";
        wr(8'h1C, 32'h1); wr(8'h38, 32'h200); wr(8'h28, 32'h1F0);
        wr(8'h24, 32'h41); idle(20);
        wr(8'h38, 32'h100); idle(10);
        wr(8'h38, 32'h300); wr(8'h30, 32'h0); idle(2);

        cur_req = "R10";
        mon_addr = 8'h18;
        wr(8'h1C, 32'h3); wr(8'h18, 32'h7);
        wr(8'h2C, 32'hFFFF_FFF0); wr(8'h38, 32'hFFFF_FFF4);
        wr(8'h28, 32'hFFFF_FFF0); wr(8'h24, 32'h43); idle(20);

        cur_req = "R12";
        wr(8'h18, 32'h7); wr(8'h1C, 32'h0); wr(8'h20, 32'h3);
        wr(8'h28, 32'hFFFF_FFF0); idle(20);
        wr(8'h20, 32'h0);

        cur_req = "R11";
        wr(8'h1C, 32'h1); wr(8'h38, 32'h800); wr(8'h24, 32'h41);
        wr(8'h28, 32'h7FE); idle(1); wr(8'h18, 32'h1); idle(3);
        wr(8'h18, 32'h1); idle(2);

        cur_req = "R13";
        wr(8'h1C, 32'h3); wr(8'h28, 32'hFFFF_FFFF); idle(2);
        wr(8'h10, 32'h0000_0002); sweep(); idle(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule